// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides whether a received CAN frame should be kept. It compares the four identifier bytes of the frame, already arranged in receive-buffer order, against a bank of eight programmable acceptance bytes. Each acceptance byte has a companion mask byte. A mask bit set to 1 removes that identifier bit from the comparison. A mask bit set to 0 requires the identifier bit to equal the acceptance bit.

The mode select splits the same eight register pairs in one of four ways: two 32-bit comparators, four 16-bit comparators, eight 8-bit comparators, or none (closed). When several comparators match, the lowest-numbered one is reported. The decision is registered one clock after the frame's valid strobe. An accepted frame produces a one-cycle pulse that sets the receive-full flag and loads a 3-bit index naming the comparator that matched.

Top module: `can_id_filter`

## Requirements
- R1: While reset is high, and on the first clock after it, accept_o is 0, hit_idx_o is 0 and rxf_set_o is 0.
- R2: A mask bit of 1 excludes the matching identifier bit from comparison. A mask bit of 0 requires that bit to equal the acceptance bit. With every mask bit set and the filter open, every strobed frame is accepted with hit index 0.
- R3: With mode_i = 2'b00, filter 0 compares registers 0–3 with identifier bytes 0–3, and filter 1 compares registers 4–7 with bytes 0–3. A hit reports index 0 or 1.
- R4: With mode_i = 2'b01, filter k (k = 0..3) compares registers 2k and 2k+1 with identifier bytes 0 and 1. Bytes 2 and 3 have no effect.
- R5: With mode_i = 2'b10, filter k (k = 0..7) compares register k with identifier byte 0. Bytes 1 to 3 have no effect.
- R6: With mode_i = 2'b11, no frame is accepted, rxf_set_o stays 0 and hit_idx_o keeps its value.
- R7: When several filters match, the lowest-numbered one sets hit_idx_o.
- R8: Outputs change on the clock edge after the edge that samples id_valid_i = 1. rxf_set_o is high for exactly one cycle per accepted frame. accept_o holds the last decision until the next strobe.
- R9: A strobed frame that matches no filter drives accept_o to 0, generates no rxf_set_o pulse and leaves hit_idx_o unchanged.
- R10: Without id_valid_i, matching identifier bytes produce no rxf_set_o pulse and do not change accept_o or hit_idx_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid_i | input | 1 | Identifier bytes valid strobe |
| id_bytes_i | input | 32 | Identifier bytes; byte n sits in bits [8n+7:8n] |
| acc_i | input | 64 | Acceptance bytes; register n sits in bits [8n+7:8n] |
| mask_i | input | 64 | Mask bytes; register n in bits [8n+7:8n], 1 = ignore |
| mode_i | input | 2 | 00 two 32-bit, 01 four 16-bit, 10 eight 8-bit, 11 closed |
| accept_o | output | 1 | Last decision: frame accepted |
| hit_idx_o | output | 3 | Index of the lowest matching filter |
| rxf_set_o | output | 1 | One-cycle pulse that sets the receive-full flag |

## Verification
The bench builds the block with its default parameters: 8-bit registers, eight register pairs and four identifier bytes. These values make every mode reachable, including all eight 8-bit comparators. They also let the bench cover the full 3-bit hit index range, from 0 to 7, and allow priority contests between neighbouring and distant filters. Under these parameters the bench checks single-bit mask exclusion and the bytes that each mode ignores. It also checks that the index is kept on misses and in closed mode.

// File: rtl/can_idf_pkg.sv
package can_idf_pkg;

    localparam int BYTE_W   = 8;
    localparam int ID_BYTES = 4;
    localparam int NUM_REGS = 8;
    localparam int HIT_W    = $clog2(NUM_REGS);

    typedef enum logic [1:0] {
        MODE_W32 = 2'b00,
        MODE_W16 = 2'b01,
        MODE_W8  = 2'b10,
        MODE_OFF = 2'b11
    } idf_mode_e;

    typedef struct packed {
        logic             hit;
        logic [HIT_W-1:0] idx;
    } idf_decision_t;

    // Identifier byte that register r is compared with in mode m
    function automatic int src_byte(idf_mode_e m, int r);
        int sel;
        case (m)
            MODE_W32: sel = r % ID_BYTES;
            MODE_W16: sel = r % 2;
            default:  sel = 0;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/can_idf_byte_cmp.sv
module can_idf_byte_cmp #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] pattern_i,
    input  logic [BYTE_W-1:0] care_n_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic              match_o
);
    logic [BYTE_W-1:0] diff;

    always_comb begin
        diff    = (pattern_i ^ data_i) & ~care_n_i;
        match_o = (diff == '0);
    end
endmodule

// File: rtl/can_idf_group.sv
module can_idf_group
    import can_idf_pkg::*;
#(
    parameter int N = 8
) (
    input  idf_mode_e      mode_i,
    input  logic [N-1:0]   reg_match_i,
    output logic [N-1:0]   filt_hit_o
);
    localparam int N16 = N / 2;
    localparam int N32 = N / 4;

    logic [N-1:0] hit_w8, hit_w16, hit_w32;

    genvar k;
    generate
        for (k = 0; k < N; k++) begin : g_w8
            assign hit_w8[k] = reg_match_i[k];
        end
        for (k = 0; k < N; k++) begin : g_w16
            if (k < N16) begin : g_on
                assign hit_w16[k] = &reg_match_i[2*k+1 : 2*k];
            end else begin : g_off
                assign hit_w16[k] = 1'b0;
            end
        end
        for (k = 0; k < N; k++) begin : g_w32
            if (k < N32) begin : g_on
                assign hit_w32[k] = &reg_match_i[4*k+3 : 4*k];
            end else begin : g_off
                assign hit_w32[k] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        case (mode_i)
            MODE_W32: filt_hit_o = hit_w32;
            MODE_W16: filt_hit_o = hit_w16;
            MODE_W8:  filt_hit_o = hit_w8;
            default:  filt_hit_o = '0;
        endcase
    end
endmodule

// File: rtl/can_idf_prio.sv
module can_idf_prio #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/can_id_filter.sv
module can_id_filter
    import can_idf_pkg::*;
#(
    parameter int BW   = BYTE_W,
    parameter int NB   = ID_BYTES,
    parameter int NR   = NUM_REGS,
    parameter int HW   = $clog2(NR)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             id_valid_i,
    input  logic [NB*BW-1:0] id_bytes_i,
    input  logic [NR*BW-1:0] acc_i,
    input  logic [NR*BW-1:0] mask_i,
    input  logic [1:0]       mode_i,
    output logic             accept_o,
    output logic [HW-1:0]    hit_idx_o,
    output logic             rxf_set_o
);
    idf_mode_e         mode;
    logic [BW-1:0]     data_sel [NR];
    logic [NR-1:0]     reg_match;
    logic [NR-1:0]     filt_hit;
    logic              any_hit;
    logic [HW-1:0]     first_idx;

    assign mode = idf_mode_e'(mode_i);

    always_comb begin
        for (int r = 0; r < NR; r++) begin
            data_sel[r] = id_bytes_i[src_byte(mode, r)*BW +: BW];
        end
    end

    genvar r;
    generate
        for (r = 0; r < NR; r++) begin : g_cmp
            can_idf_byte_cmp #(.BYTE_W(BW)) u_cmp (
                .pattern_i (acc_i[r*BW +: BW]),
                .care_n_i  (mask_i[r*BW +: BW]),
                .data_i    (data_sel[r]),
                .match_o   (reg_match[r])
            );
        end
    endgenerate

    can_idf_group #(.N(NR)) u_group (
        .mode_i      (mode),
        .reg_match_i (reg_match),
        .filt_hit_o  (filt_hit)
    );

    can_idf_prio #(.N(NR), .IDX_W(HW)) u_prio (
        .req_i (filt_hit),
        .any_o (any_hit),
        .idx_o (first_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            accept_o  <= 1'b0;
            hit_idx_o <= '0;
            rxf_set_o <= 1'b0;
        end else begin
            rxf_set_o <= 1'b0;
            if (id_valid_i) begin
                accept_o  <= any_hit;
                rxf_set_o <= any_hit;
                if (any_hit) hit_idx_o <= first_idx;
            end
        end
    end
endmodule

// File: rtl/can_idf_checker.sv
module can_idf_checker #(
    parameter int NR = 8,
    parameter int BW = 8,
    parameter int HW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          id_valid_i,
    input logic [NR*BW-1:0] mask_i,
    input logic [1:0]    mode_i,
    input logic          accept_o,
    input logic [HW-1:0] hit_idx_o,
    input logic          rxf_set_o
);
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (!accept_o && hit_idx_o == '0 && !rxf_set_o));

    p_all_masked_r2: assert property (@(posedge clk) disable iff (rst)
        (id_valid_i && mode_i != 2'b11 && (&mask_i)) |=> (rxf_set_o && hit_idx_o == '0));

    p_closed_r6: assert property (@(posedge clk) disable iff (rst)
        (id_valid_i && mode_i == 2'b11) |=> (!rxf_set_o && !accept_o));

    p_pulse_accept_r8: assert property (@(posedge clk) disable iff (rst)
        rxf_set_o |-> accept_o);

    p_idx_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !rxf_set_o |-> $stable(hit_idx_o));

    p_no_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        !id_valid_i |=> (!rxf_set_o && $stable(accept_o)));
endmodule

bind can_id_filter can_idf_checker #(.NR(NR), .BW(BW), .HW(HW)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .id_valid_i (id_valid_i),
    .mask_i     (mask_i),
    .mode_i     (mode_i),
    .accept_o   (accept_o),
    .hit_idx_o  (hit_idx_o),
    .rxf_set_o  (rxf_set_o)
);

// File: tb/can_id_filter_tb_top.sv
`timescale 1ns/1ps
module can_id_filter_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        id_valid_i;
    logic [31:0] id_bytes_i;
    logic [63:0] acc_i;
    logic [63:0] mask_i;
    logic [1:0]  mode_i;
    logic        accept_o;
    logic [2:0]  hit_idx_o;
    logic        rxf_set_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    can_id_filter dut_i (
        .clk(clk), .rst(rst), .id_valid_i(id_valid_i), .id_bytes_i(id_bytes_i),
        .acc_i(acc_i), .mask_i(mask_i), .mode_i(mode_i),
        .accept_o(accept_o), .hit_idx_o(hit_idx_o), .rxf_set_o(rxf_set_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_reg(input int k, input logic [7:0] a, input logic [7:0] m);
        acc_i[k*8 +: 8]  = a;
        mask_i[k*8 +: 8] = m;
    endtask

    function automatic logic [31:0] idw(input logic [7:0] b0, b1, b2, b3);
        return {b3, b2, b1, b0};
    endfunction

    // Strobe one frame; returns at the negedge after the registering edge
    task automatic send(input logic [31:0] idb, input logic [1:0] md);
        @(negedge clk);
        id_bytes_i = idb;
        mode_i     = md;
        id_valid_i = 1'b1;
        @(negedge clk);
        id_valid_i = 1'b0;
    endtask

    task automatic expect_out(input string req, input int acc, input int idx, input int pulse);
        chk({req, " accept"}, int'(accept_o), acc);
        chk({req, " hit_idx"}, int'(hit_idx_o), idx);
        chk({req, " rxf_set"}, int'(rxf_set_o), pulse);
    endtask

    task automatic t_reset_r1();
        rst = 1'b1; id_valid_i = 1'b0; id_bytes_i = '0; mode_i = 2'b00;
        acc_i = '0; mask_i = '1;
        repeat (3) @(negedge clk);
        expect_out("R1", 0, 0, 0);
        rst = 1'b0;
        @(negedge clk);
        expect_out("R1", 0, 0, 0);
    endtask

    task automatic t_mask_r2();
        send(idw(8'h3c, 8'h91, 8'h07, 8'he2), 2'b10);
        expect_out("R2 all masked", 1, 0, 1);
        set_reg(0, 8'h12, 8'h00); set_reg(1, 8'h34, 8'h00);
        set_reg(2, 8'h56, 8'h00); set_reg(3, 8'h78, 8'h00);
        for (int k = 4; k < 8; k++) set_reg(k, 8'h00, 8'h00);
        send(idw(8'h12, 8'h34, 8'h56, 8'h79), 2'b00);
        expect_out("R2 one bit differs", 0, 0, 0);
        set_reg(3, 8'h78, 8'h01);
        send(idw(8'h12, 8'h34, 8'h56, 8'h79), 2'b00);
        expect_out("R2 differing bit masked", 1, 0, 1);
    endtask

    task automatic t_w32_r3();
        set_reg(3, 8'h78, 8'h00);
        set_reg(4, 8'haa, 8'h00); set_reg(5, 8'hbb, 8'h00);
        set_reg(6, 8'hcc, 8'h00); set_reg(7, 8'hdd, 8'h00);
        send(idw(8'haa, 8'hbb, 8'hcc, 8'hdd), 2'b00);
        expect_out("R3 filter1", 1, 1, 1);
        send(idw(8'h12, 8'h34, 8'h56, 8'h78), 2'b00);
        expect_out("R3 filter0", 1, 0, 1);
        send(idw(8'haa, 8'hbb, 8'hcc, 8'hde), 2'b00);
        expect_out("R3 byte3 compared", 0, 0, 0);
    endtask

    task automatic t_w16_r4();
        set_reg(0, 8'h11, 8'h00); set_reg(1, 8'h22, 8'h00);
        set_reg(2, 8'h33, 8'h00); set_reg(3, 8'h44, 8'h00);
        set_reg(4, 8'h55, 8'h00); set_reg(5, 8'h66, 8'h00);
        set_reg(6, 8'h77, 8'h00); set_reg(7, 8'h88, 8'h00);
        send(idw(8'h55, 8'h66, 8'hf0, 8'h0f), 2'b01);
        expect_out("R4 filter2", 1, 2, 1);
        send(idw(8'h77, 8'h88, 8'h12, 8'h34), 2'b01);
        expect_out("R4 filter3 bytes2-3 ignored", 1, 3, 1);
        send(idw(8'h33, 8'h44, 8'h00, 8'h00), 2'b01);
        expect_out("R4 filter1", 1, 1, 1);
    endtask

    task automatic t_w8_r5();
        for (int k = 0; k < 8; k++) set_reg(k, 8'(8'h10 + k), 8'h00);
        send(idw(8'h15, 8'h10, 8'h11, 8'h12), 2'b10);
        expect_out("R5 filter5 only byte0", 1, 5, 1);
        send(idw(8'h17, 8'h00, 8'h00, 8'h00), 2'b10);
        expect_out("R5 filter7", 1, 7, 1);
    endtask

    task automatic t_prio_r7();
        set_reg(6, 8'h16, 8'hff);
        send(idw(8'h15, 8'h00, 8'h00, 8'h00), 2'b10);
        expect_out("R7 5 beats 6", 1, 5, 1);
        send(idw(8'h99, 8'h00, 8'h00, 8'h00), 2'b10);
        expect_out("R7 only 6", 1, 6, 1);
        set_reg(2, 8'h12, 8'hff);
        send(idw(8'h15, 8'h00, 8'h00, 8'h00), 2'b10);
        expect_out("R7 2 beats 5 and 6", 1, 2, 1);
    endtask

    task automatic t_pulse_r8();
        // prior send left hit 2 accepted; pulse must be gone next cycle
        @(negedge clk);
        expect_out("R8 pulse one cycle", 1, 2, 0);
    endtask

    task automatic t_nomatch_r9();
        set_reg(2, 8'h12, 8'h00); set_reg(6, 8'h16, 8'h00);
        send(idw(8'hee, 8'h00, 8'h00, 8'h00), 2'b10);
        expect_out("R9 miss keeps idx", 0, 2, 0);
    endtask

    task automatic t_closed_r6();
        mask_i = '1;
        send(idw(8'h15, 8'h00, 8'h00, 8'h00), 2'b11);
        expect_out("R6 closed", 0, 2, 0);
    endtask

    task automatic t_nostrobe_r10();
        send(idw(8'h00, 8'h00, 8'h00, 8'h00), 2'b10);
        expect_out("R10 setup", 1, 0, 1);
        for (int k = 0; k < 8; k++) set_reg(k, 8'(8'h10 + k), 8'h00);
        @(negedge clk);
        id_bytes_i = idw(8'h14, 8'h00, 8'h00, 8'h00);
        repeat (3) @(negedge clk);
        expect_out("R10 no strobe", 1, 0, 0);
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset_r1();
        t_mask_r2();
        t_w32_r3();
        t_w16_r4();
        t_w8_r5();
        t_prio_r7();
        t_pulse_r8();
        t_nomatch_r9();
        t_closed_r6();
        t_nostrobe_r10();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule